// File: doc/BRIEF.md
# Image-Analysis Job Control Register Bank

This block is the register bank of a fixed-function image-analysis engine. It sits on a 32-bit register bus and holds everything software sets up before a job: two buffer base addresses aligned to 32 bytes, the detection-area window (start and size on each axis), a condition register that selects the smallest object size and the scan orientation, and a match threshold. Every field is also driven out to the engine on a dedicated port.

Software starts a job by setting a run bit. The block sends a one-cycle start pulse to the engine and holds the run bit high until the engine reports completion. When the engine's done input arrives, the run bit drops and a sticky finish flag is set in the same clock edge. The engine's result count is captured, and a one-cycle done event goes to the interrupt logic. Software clears the finish flag by writing 1 to it. A software-reset bit puts every field back to its reset value. It reads as 1 for a fixed number of cycles and then clears itself.

Bus access takes one cycle: writes take effect at the clock edge that samples `bus_wr`, and read data appears on `bus_rdata` after the edge that samples `bus_rd` and holds until the next read.

Top module: `jobctl_regs`

## Requirements
- R1: After the reset input, each register reads as follows: control 0, count 0, both base addresses 0, condition 0, start X 0, start Y 0, size X 0x140, size Y 0xF0, threshold 5.
- R2: The image base (offset 0x08) and work base (offset 0x0C) keep only bits 31:5. Bits 4:0 always read 0, on the bus and on the cfg ports.
- R3: Writing 1 to control bit 0 (RUN) at offset 0x00 while idle has two effects after that edge: RUN reads 1 and `eng_start` is high for exactly one cycle. The count register is cleared when a job starts.
- R4: An `eng_done` pulse while RUN is 1 takes effect at one edge. RUN clears, control bit 1 (FINISH) sets, `done_evt` is high for one cycle, and the count register (offset 0x04, 6 bits) captures `eng_count`, saturated at 35.
- R5: Writing 1 to FINISH clears it, and writing 0 leaves it unchanged. If a done pulse and a clear arrive at the same edge, FINISH ends up set.
- R6: Writing 1 to control bit 2 (soft reset) returns every field to its R1 value. The bit reads 1 for 4 cycles and then clears itself. Writing 0 to it has no effect.
- R7: Writes to configuration registers (offsets 0x08 to 0x24) are ignored while RUN is 1, and so is a RUN write while RUN is 1.
- R8: The condition register (0x10) holds the minimum size in bits 1:0 (0..3 = 20, 25, 32, 40 pixels) and the direction in bits 3:2 (0 up, 1 right, 2 left). A write whose direction field is 3 is ignored as a whole.
- R9: The threshold register (0x24, 4 bits) accepts only values 0 to 9. A larger value is ignored.
- R10: Start X (0x14) is 8 bits, start Y (0x18) 7 bits, size X (0x1C) 9 bits and size Y (0x20) 8 bits. Unused bits and unmapped offsets read 0.
- R11: An `eng_done` pulse while idle produces no done event and changes neither FINISH nor the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| eng_start | output | 1 | One-cycle job start pulse |
| eng_run | output | 1 | Job in progress (RUN bit) |
| eng_done | input | 1 | Engine completion pulse |
| eng_count | input | 6 | Number of results found by the engine |
| done_evt | output | 1 | One-cycle completion event for interrupt logic |
| cfg_pic_base | output | 32 | Image buffer base address |
| cfg_work_base | output | 32 | Work buffer base address |
| cfg_min_size | output | 2 | Minimum object size code |
| cfg_dir | output | 2 | Scan direction code |
| cfg_start_x | output | 8 | Window start X |
| cfg_start_y | output | 7 | Window start Y |
| cfg_size_x | output | 9 | Window width |
| cfg_size_y | output | 8 | Window height |
| cfg_thresh | output | 4 | Match threshold |

## Verification
The hardest case to reach from the ports is an engine completion and a software clear of FINISH arriving at the same clock edge. The bench drives the done input and the control write on the same falling edge, so that one rising edge samples both. The soft reset's in-progress window is also short. The bench reaches it by issuing a read on the cycle right after the reset write, while a job is running and the fields hold non-reset values. Every engine count from 0 to 63 goes through a full job, so the saturation at 35 is covered on both sides.

// File: rtl/jobctl_pkg.sv
package jobctl_pkg;
  // register byte offsets
  localparam int OFF_CTRL  = 'h00;
  localparam int OFF_COUNT = 'h04;
  localparam int OFF_PIC   = 'h08;
  localparam int OFF_WORK  = 'h0C;
  localparam int OFF_COND  = 'h10;
  localparam int OFF_SX    = 'h14;
  localparam int OFF_SY    = 'h18;
  localparam int OFF_WX    = 'h1C;
  localparam int OFF_WY    = 'h20;
  localparam int OFF_THR   = 'h24;

  // control bit positions
  localparam int CTRL_RUN  = 0;
  localparam int CTRL_FIN  = 1;
  localparam int CTRL_SRST = 2;

  // field widths
  localparam int SX_W  = 8;
  localparam int SY_W  = 7;
  localparam int WX_W  = 9;
  localparam int WY_W  = 8;
  localparam int THR_W = 4;

  // reset values and limits
  localparam logic [WX_W-1:0]  WX_RST  = 9'h140;
  localparam logic [WY_W-1:0]  WY_RST  = 8'hF0;
  localparam logic [THR_W-1:0] THR_RST = 4'd5;
  localparam logic [THR_W-1:0] THR_MAX = 4'd9;

  typedef enum logic [1:0] {DIR_UP = 2'd0, DIR_RIGHT = 2'd1, DIR_LEFT = 2'd2, DIR_RSVD = 2'd3} dir_e;
  typedef enum logic [1:0] {MIN_20 = 2'd0, MIN_25 = 2'd1, MIN_32 = 2'd2, MIN_40 = 2'd3} min_e;
endpackage

// File: rtl/jobctl_seq.sv
module jobctl_seq #(
  parameter int CNT_W       = 6,
  parameter int MAX_RESULTS = 35,
  parameter int SRST_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_wr,
  input  logic [2:0]       ctrl_wdata,
  input  logic             eng_done,
  input  logic [CNT_W-1:0] eng_count,
  output logic             run_q,
  output logic             fin_q,
  output logic             start_q,
  output logic             done_q,
  output logic             srst_busy,
  output logic             srst_req,
  output logic [CNT_W-1:0] count_q
);
  import jobctl_pkg::*;

  localparam int SR_W = $clog2(SRST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_RESULTS);

  logic [SR_W-1:0] sr_cnt;
  logic            done_hit;
  logic            clr;

  assign srst_req = ctrl_wr && ctrl_wdata[CTRL_SRST] && !srst_busy;
  assign clr      = rst || srst_req || srst_busy;
  assign done_hit = run_q && eng_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      srst_busy <= 1'b0;
      sr_cnt    <= '0;
    end else if (srst_req) begin
      srst_busy <= 1'b1;
      sr_cnt    <= SR_W'(SRST_CYCLES - 1);
    end else if (srst_busy) begin
      if (sr_cnt == '0) srst_busy <= 1'b0;
      else              sr_cnt    <= sr_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      run_q   <= 1'b0;
      fin_q   <= 1'b0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
      count_q <= '0;
    end else begin
      start_q <= 1'b0;
      done_q  <= done_hit;
      if (done_hit) begin
        run_q   <= 1'b0;
        count_q <= (eng_count > CNT_SAT) ? CNT_SAT : eng_count;
      end else if (ctrl_wr && ctrl_wdata[CTRL_RUN] && !run_q) begin
        run_q   <= 1'b1;
        start_q <= 1'b1;
        count_q <= '0;
      end
      if (ctrl_wr && ctrl_wdata[CTRL_FIN]) fin_q <= 1'b0;
      if (done_hit)                        fin_q <= 1'b1;
    end
  end
endmodule

// File: rtl/jobctl_cfg.sv
module jobctl_cfg #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int ALIGN_BITS = 5
) (
  input  logic                            clk,
  input  logic                            clr,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               wdata,
  output logic [1:0][DATA_W-1:0]          bases,
  output logic [1:0]                      min_size,
  output logic [1:0]                      dir,
  output logic [jobctl_pkg::SX_W-1:0]     start_x,
  output logic [jobctl_pkg::SY_W-1:0]     start_y,
  output logic [jobctl_pkg::WX_W-1:0]     size_x,
  output logic [jobctl_pkg::WY_W-1:0]     size_y,
  output logic [jobctl_pkg::THR_W-1:0]    thresh
);
  import jobctl_pkg::*;

  for (genvar b = 0; b < 2; b++) begin : g_base
    localparam int OFF = (b == 0) ? OFF_PIC : OFF_WORK;
    logic [DATA_W-1:ALIGN_BITS] hi_q;
    always_ff @(posedge clk) begin
      if (clr)                                 hi_q <= '0;
      else if (wr_en && addr == ADDR_W'(OFF))  hi_q <= wdata[DATA_W-1:ALIGN_BITS];
    end
    assign bases[b] = {hi_q, {ALIGN_BITS{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      min_size <= MIN_20;
      dir      <= DIR_UP;
      start_x  <= '0;
      start_y  <= '0;
      size_x   <= WX_RST;
      size_y   <= WY_RST;
      thresh   <= THR_RST;
    end else if (wr_en) begin
      if (addr == ADDR_W'(OFF_COND) && wdata[3:2] != DIR_RSVD) begin
        min_size <= wdata[1:0];
        dir      <= wdata[3:2];
      end
      if (addr == ADDR_W'(OFF_SX)) start_x <= wdata[SX_W-1:0];
      if (addr == ADDR_W'(OFF_SY)) start_y <= wdata[SY_W-1:0];
      if (addr == ADDR_W'(OFF_WX)) size_x  <= wdata[WX_W-1:0];
      if (addr == ADDR_W'(OFF_WY)) size_y  <= wdata[WY_W-1:0];
      if (addr == ADDR_W'(OFF_THR) && wdata[THR_W-1:0] <= THR_MAX)
        thresh <= wdata[THR_W-1:0];
    end
  end
endmodule

// File: rtl/jobctl_rdmux.sv
module jobctl_rdmux #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [2:0]                   ctrl_bits,
  input  logic [CNT_W-1:0]             count,
  input  logic [1:0][DATA_W-1:0]       bases,
  input  logic [1:0]                   min_size,
  input  logic [1:0]                   dir,
  input  logic [jobctl_pkg::SX_W-1:0]  start_x,
  input  logic [jobctl_pkg::SY_W-1:0]  start_y,
  input  logic [jobctl_pkg::WX_W-1:0]  size_x,
  input  logic [jobctl_pkg::WY_W-1:0]  size_y,
  input  logic [jobctl_pkg::THR_W-1:0] thresh,
  output logic [DATA_W-1:0]            rdata
);
  import jobctl_pkg::*;

  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    case (addr)
      ADDR_W'(OFF_CTRL):  sel = DATA_W'(ctrl_bits);
      ADDR_W'(OFF_COUNT): sel = DATA_W'(count);
      ADDR_W'(OFF_PIC):   sel = bases[0];
      ADDR_W'(OFF_WORK):  sel = bases[1];
      ADDR_W'(OFF_COND):  sel = DATA_W'({dir, min_size});
      ADDR_W'(OFF_SX):    sel = DATA_W'(start_x);
      ADDR_W'(OFF_SY):    sel = DATA_W'(start_y);
      ADDR_W'(OFF_WX):    sel = DATA_W'(size_x);
      ADDR_W'(OFF_WY):    sel = DATA_W'(size_y);
      ADDR_W'(OFF_THR):   sel = DATA_W'(thresh);
      default:            sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= sel;
  end
endmodule

// File: rtl/jobctl_regs.sv
module jobctl_regs #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int ALIGN_BITS  = 5,
  parameter int CNT_W       = 6,
  parameter int MAX_RESULTS = 35,
  parameter int SRST_CYCLES = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic [DATA_W-1:0]            bus_rdata,
  output logic                         eng_start,
  output logic                         eng_run,
  input  logic                         eng_done,
  input  logic [CNT_W-1:0]             eng_count,
  output logic                         done_evt,
  output logic [DATA_W-1:0]            cfg_pic_base,
  output logic [DATA_W-1:0]            cfg_work_base,
  output logic [1:0]                   cfg_min_size,
  output logic [1:0]                   cfg_dir,
  output logic [jobctl_pkg::SX_W-1:0]  cfg_start_x,
  output logic [jobctl_pkg::SY_W-1:0]  cfg_start_y,
  output logic [jobctl_pkg::WX_W-1:0]  cfg_size_x,
  output logic [jobctl_pkg::WY_W-1:0]  cfg_size_y,
  output logic [jobctl_pkg::THR_W-1:0] cfg_thresh
);
  import jobctl_pkg::*;

  logic                    ctrl_wr, cfg_wr, cfg_clr;
  logic                    run_q, fin_q, srst_busy, srst_req;
  logic [CNT_W-1:0]        count_q;
  logic [1:0][DATA_W-1:0]  bases;

  assign ctrl_wr = bus_wr && bus_addr == ADDR_W'(OFF_CTRL);
  assign cfg_wr  = bus_wr && !run_q && !srst_busy;
  assign cfg_clr = rst || srst_req || srst_busy;

  jobctl_seq #(.CNT_W(CNT_W), .MAX_RESULTS(MAX_RESULTS), .SRST_CYCLES(SRST_CYCLES)) seq_i (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(bus_wdata[2:0]),
    .eng_done(eng_done), .eng_count(eng_count),
    .run_q(run_q), .fin_q(fin_q), .start_q(eng_start), .done_q(done_evt),
    .srst_busy(srst_busy), .srst_req(srst_req), .count_q(count_q)
  );

  jobctl_cfg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS)) cfg_i (
    .clk(clk), .clr(cfg_clr), .wr_en(cfg_wr), .addr(bus_addr), .wdata(bus_wdata),
    .bases(bases), .min_size(cfg_min_size), .dir(cfg_dir),
    .start_x(cfg_start_x), .start_y(cfg_start_y),
    .size_x(cfg_size_x), .size_y(cfg_size_y), .thresh(cfg_thresh)
  );

  jobctl_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) rdmux_i (
    .clk(clk), .rst(rst), .rd_en(bus_rd), .addr(bus_addr),
    .ctrl_bits({srst_busy, fin_q, run_q}), .count(count_q), .bases(bases),
    .min_size(cfg_min_size), .dir(cfg_dir),
    .start_x(cfg_start_x), .start_y(cfg_start_y),
    .size_x(cfg_size_x), .size_y(cfg_size_y), .thresh(cfg_thresh),
    .rdata(bus_rdata)
  );

  assign eng_run       = run_q;
  assign cfg_pic_base  = bases[0];
  assign cfg_work_base = bases[1];
endmodule

// File: rtl/jobctl_chk.sv
module jobctl_chk #(
  parameter int ADDR_W      = 8,
  parameter int CNT_W       = 6,
  parameter int MAX_RESULTS = 35
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wd_run,
  input logic              wd_srst,
  input logic              eng_run,
  input logic              eng_start,
  input logic              eng_done,
  input logic              done_evt,
  input logic              srst_busy,
  input logic [CNT_W-1:0]  count_q,
  input logic [3:0]        cfg_thresh,
  input logic [7:0]        cfg_start_x
);
  logic ctrl_hit;
  assign ctrl_hit = bus_wr && bus_addr == ADDR_W'(0);

  // R3
  start_run_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_hit && wd_run && !wd_srst && !eng_run && !srst_busy) |=> (eng_run && eng_start));

  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);

  // R4
  done_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_run && eng_done && !(ctrl_hit && wd_srst)) |=> (!eng_run && done_evt));

  // R11
  idle_done_chk: assert property (@(posedge clk) disable iff (rst)
    done_evt |-> $past(eng_run));

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_run && $past(eng_run)) |-> ($stable(cfg_thresh) && $stable(cfg_start_x)));

  // R9
  thr_range_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_thresh <= 4'd9);

  // R4
  count_max_chk: assert property (@(posedge clk) disable iff (rst)
    count_q <= CNT_W'(MAX_RESULTS));
endmodule

bind jobctl_regs jobctl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_RESULTS(MAX_RESULTS)) chk_i (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wd_run(bus_wdata[0]), .wd_srst(bus_wdata[2]),
  .eng_run(eng_run), .eng_start(eng_start), .eng_done(eng_done), .done_evt(done_evt),
  .srst_busy(srst_busy), .count_q(count_q), .cfg_thresh(cfg_thresh), .cfg_start_x(cfg_start_x)
);

// File: tb/jobctl_regs_tb.sv
`timescale 1ns/1ps
module jobctl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eng_start, eng_run, eng_done = 1'b0, done_evt;
  logic [5:0]  eng_count = '0;
  logic [31:0] pic_b, work_b;
  logic [1:0]  min_s, dir_s;
  logic [7:0]  sx;
  logic [6:0]  sy;
  logic [8:0]  wx;
  logic [7:0]  wy;
  logic [3:0]  thr;

  int errors = 0;
  int checks = 0;
  logic [31:0] rv;
  logic        done_flag = 1'b0;

  always #2 clk = ~clk;

  jobctl_regs dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_start(eng_start), .eng_run(eng_run),
    .eng_done(eng_done), .eng_count(eng_count), .done_evt(done_evt),
    .cfg_pic_base(pic_b), .cfg_work_base(work_b), .cfg_min_size(min_s), .cfg_dir(dir_s),
    .cfg_start_x(sx), .cfg_start_y(sy), .cfg_size_x(wx), .cfg_size_y(wy), .cfg_thresh(thr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic pulse_done(input logic [5:0] c);
    @(negedge clk); eng_done = 1'b1; eng_count = c;
    @(negedge clk); eng_done = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!done_flag && cyc < 150000) begin
      @(posedge clk); cyc++;
    end
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [4];
    logic [31:0] exp_cond, exp_thr;
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h1234_5678; pats[2] = 32'h0000_001F; pats[3] = 32'hA5A5_A5A3;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    rd(8'h00, rv); check("R1 ctrl", rv, 0);
    rd(8'h04, rv); check("R1 count", rv, 0);
    rd(8'h08, rv); check("R1 pic", rv, 0);
    rd(8'h0C, rv); check("R1 work", rv, 0);
    rd(8'h10, rv); check("R1 cond", rv, 0);
    rd(8'h14, rv); check("R1 sx", rv, 0);
    rd(8'h18, rv); check("R1 sy", rv, 0);
    rd(8'h1C, rv); check("R1 wx", rv, 32'h140);
    rd(8'h20, rv); check("R1 wy", rv, 32'hF0);
    rd(8'h24, rv); check("R1 thr", rv, 5);

    // R2 alignment
    for (int i = 0; i < 4; i++) begin
      wr(8'h08, pats[i]);
      wr(8'h0C, ~pats[i]);
      rd(8'h08, rv); check("R2 pic", rv, pats[i] & 32'hFFFF_FFE0);
      rd(8'h0C, rv); check("R2 work", rv, ~pats[i] & 32'hFFFF_FFE0);
      check("R2 pic port", pic_b, pats[i] & 32'hFFFF_FFE0);
    end

    // R8 condition sweep
    exp_cond = 0;
    for (int v = 0; v < 16; v++) begin
      wr(8'h10, 32'hFFFF_FFF0 | v);
      if ((v >> 2) != 3) exp_cond = v;
      rd(8'h10, rv); check("R8 cond", rv, exp_cond);
      check("R8 dir port", {30'd0, dir_s}, exp_cond >> 2);
    end

    // R9 threshold sweep
    exp_thr = 5;
    for (int v = 0; v < 16; v++) begin
      wr(8'h24, v);
      if (v <= 9) exp_thr = v;
      rd(8'h24, rv); check("R9 thr", rv, exp_thr);
    end

    // R10 field widths and unmapped
    wr(8'h14, '1); rd(8'h14, rv); check("R10 sx", rv, 32'hFF);
    wr(8'h18, '1); rd(8'h18, rv); check("R10 sy", rv, 32'h7F);
    wr(8'h1C, '1); rd(8'h1C, rv); check("R10 wx", rv, 32'h1FF);
    wr(8'h20, '1); rd(8'h20, rv); check("R10 wy", rv, 32'hFF);
    rd(8'h40, rv); check("R10 unmapped", rv, 0);
    rd(8'h28, rv); check("R10 unmapped", rv, 0);

    // R3/R4/R7/R5: every engine count
    wr(8'h24, 3);
    for (int v = 0; v < 64; v++) begin
      wr(8'h00, 32'h1);
      check("R3 start pulse", {31'd0, eng_start}, 1);
      @(negedge clk);
      check("R3 start one cycle", {31'd0, eng_start}, 0);
      rd(8'h04, rv); check("R3 count cleared", rv, 0);
      rd(8'h00, rv); check("R3 run", rv, 1);
      wr(8'h24, 7);            // R7 ignored while running
      wr(8'h00, 32'h1);        // R7 second run write no effect
      check("R7 no restart", {31'd0, eng_start}, 0);
      rd(8'h24, rv); check("R7 thr held", rv, 3);
      pulse_done(v[5:0]);
      check("R4 done_evt", {31'd0, done_evt}, 1);
      @(negedge clk);
      check("R4 done_evt one cycle", {31'd0, done_evt}, 0);
      rd(8'h00, rv); check("R4 finish", rv, 2);
      rd(8'h04, rv); check("R4 count", rv, (v > 35) ? 35 : v);
      wr(8'h00, 32'h0);
      rd(8'h00, rv); check("R5 write0 keeps", rv, 2);
      wr(8'h00, 32'h2);
      rd(8'h00, rv); check("R5 w1c", rv, 0);
    end

    // R11 done while idle
    pulse_done(6'd7);
    check("R11 no evt", {31'd0, done_evt}, 0);
    rd(8'h00, rv); check("R11 ctrl", rv, 0);
    rd(8'h04, rv); check("R11 count", rv, 35);

    // R5 set wins over simultaneous clear
    wr(8'h00, 32'h1);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h2; eng_done = 1'b1; eng_count = 6'd4;
    @(negedge clk);
    bus_wr = 1'b0; eng_done = 1'b0;
    rd(8'h00, rv); check("R5 set wins", rv, 2);

    // R6 soft reset during a job
    wr(8'h00, 32'h2);
    wr(8'h14, 32'h0A);
    wr(8'h08, 32'h4000_0000);
    wr(8'h00, 32'h1);
    wr(8'h00, 32'h0);
    rd(8'h00, rv); check("R6 write0 no reset", rv, 1);
    wr(8'h00, 32'h4);
    rd(8'h00, rv); check("R6 busy reads 1", rv, 4);
    repeat (6) @(negedge clk);
    rd(8'h00, rv); check("R6 self clear", rv, 0);
    rd(8'h14, rv); check("R6 sx reset", rv, 0);
    rd(8'h08, rv); check("R6 pic reset", rv, 0);
    rd(8'h1C, rv); check("R6 wx reset", rv, 32'h140);
    rd(8'h24, rv); check("R6 thr reset", rv, 5);
    rd(8'h04, rv); check("R6 count reset", rv, 0);
    check("R6 run port", {31'd0, eng_run}, 0);

    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule